// File: doc/BRIEF.md
# Four-Channel Edge-Aligned PWM Timer with Output Break

This block produces up to four edge-aligned pulse-width-modulated outputs, each with an optional inverted companion output. All channels share one clock prescaler and one up-counter. Each channel has its own compare threshold and its own enable and polarity controls. A global output-drive flag gates every output. Up to two break inputs, each with a selectable active level and a consecutive-sample filter, can force all outputs to their idle level.

Software sets the block up through a single-cycle register write port and a combinational read port. The active prescaler, reload and compare values are loaded from buffer registers only at an update event. An update event is either a counter wrap or a software-requested update. This lets a new period and duty take effect together at a period boundary.

Top module: `pwm_timer`

Register map (addresses on `wr_addr`/`rd_addr`):
- 0 control: bit0 count run, bit1 reload buffering, bit2 automatic drive restore, bit3 global output drive, bit4 (write-only, reads 0) request update.
- 1 prescaler buffer.
- 2 reload buffer.
- 3 channel config: nibble per channel c at bits 4c..4c+3 = {companion polarity, companion enable, polarity, enable}, enable at 4c.
- 4 break config: byte per input b at bits 8b..8b+7: bit 8b enable, bit 8b+1 active level (1 = high), bits 8b+4..8b+7 filter length F.
- 8+c compare buffer of channel c.

## Requirements
- R1: After reset every register reads zero, the counter stands at zero and every output is low.
- R2: While running, the counter advances once every (prescaler+1) clocks, counts 0 to the reload value and then wraps to 0, so one period is (prescaler+1)*(reload+1) clocks.
- R3: A channel's reference level is high while the counter is below its active compare value and low otherwise. A compare of 0 therefore gives a constant low, and a compare above the reload value gives a constant high.
- R4: When a channel is enabled and the outputs are driven, the main output equals the reference level XOR its polarity bit. Otherwise the main output sits at its polarity bit.
- R5: When its enable is set and the outputs are driven, the companion output equals the inverted reference level XOR its own polarity bit. Otherwise it sits at its companion polarity bit.
- R6: With reload buffering set, a reload write takes effect only at the next update event. With it clear, the written reload value governs the counter from the next clock on, and a counter at or above it wraps at its next tick.
- R7: Writing 1 to the update-request bit restarts the counter and prescaler at zero and copies the prescaler, reload and compare buffers into the active registers. Buffer writes alone change no output.
- R8: With the run bit clear, the counter holds its value and the outputs hold their pattern.
- R9: With the global output-drive flag clear, every output sits at its own polarity bit.
- R10: An enabled break input trips once it has been at its active level for F+1 consecutive clock samples, with F=0 tripping in the same cycle. While it is tripped, all outputs go to their idle level and the drive flag is cleared. A disabled break input has no effect.
- R11: With automatic drive restore set, the drive flag is set again at the first update event with no break tripped. With it clear, the flag stays clear until software sets it.
- R12: Channel-config bits of missing channels or absent companion outputs, bytes of missing break inputs, compare addresses of missing channels, and the update-request bit all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| brk_in | input | NUM_BRK | Break inputs, already synchronised to clk |
| pwm_out | output | NUM_CH | Main channel outputs |
| pwm_out_n | output | NUM_CH | Companion channel outputs |

## Verification
The bench builds the timer with three channels, companion outputs, one break input, a 4-bit counter and a 2-bit prescaler. The narrow counter and prescaler let every prescaler value and several reload values be swept through whole periods in a few thousand cycles. The compare values in the sweep include zero and values above the reload. The missing fourth channel and second break input make the zero-readback rules observable. One break input with a 4-bit filter is enough to check the exact trip sample count against short and long pulses at both active levels.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int ADDR_W     = 4;
   localparam int FILT_W     = 4;
   localparam int CFG_STRIDE = 4;
   localparam int BRK_STRIDE = 8;

   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
   localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
   localparam logic [ADDR_W-1:0] A_RELOAD = 4'd2;
   localparam logic [ADDR_W-1:0] A_CHCFG  = 4'd3;
   localparam logic [ADDR_W-1:0] A_BRK    = 4'd4;
   localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

   localparam int B_RUN = 0;
   localparam int B_PRE = 1;
   localparam int B_AOE = 2;
   localparam int B_MOE = 3;
   localparam int B_UG  = 4;
endpackage

// File: rtl/pwmt_count.sv
module pwmt_count #(
   parameter int PSC_W = 16,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             force_i,
   input  logic [PSC_W-1:0] psc_i,
   input  logic [CNT_W-1:0] arr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             upd_o
);
   logic [PSC_W-1:0] pc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             wrap;

   assign tick  = run_i && (pc_q >= psc_i);
   assign wrap  = tick && (cnt_q >= arr_i);
   assign upd_o = force_i | wrap;
   assign cnt_o = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         cnt_q <= '0;
      end else if (force_i) begin
         pc_q  <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         pc_q  <= '0;
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end else if (run_i) begin
         pc_q  <= pc_q + 1'b1;
      end
   end

   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_i |=> (cnt_q == '0 && pc_q == '0));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !force_i) |=> $stable(cnt_q));

   assert_psc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !force_i && pc_q < psc_i) |=> ($stable(cnt_q) && pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/pwmt_brk.sv
module pwmt_brk #(
   parameter int FILT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              lvl_i,
   input  logic [FILT_W-1:0] filt_i,
   input  logic              raw_i,
   output logic              trip_o
);
   logic              act;
   logic [FILT_W-1:0] run_q;

   assign act    = en_i && (raw_i == lvl_i);
   assign trip_o = act && (run_q >= filt_i);

   always_ff @(posedge clk) begin
      if (!rst_n)         run_q <= '0;
      else if (!act)      run_q <= '0;
      else if (run_q != '1) run_q <= run_q + 1'b1;
   end

   assert_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_o && filt_i != '0) |-> $past(en_i && (raw_i == lvl_i)));
endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan #(
   parameter int CNT_W    = 16,
   parameter int HAS_COMP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             en_i,
   input  logic             pol_i,
   input  logic             cen_i,
   input  logic             cpol_i,
   input  logic             gate_i,
   output logic             out_o,
   output logic             out_n_o
);
   logic ref_lvl;

   assign ref_lvl = cnt_i < cmp_i;
   assign out_o   = (gate_i && en_i) ? (ref_lvl ^ pol_i) : pol_i;

   generate
      if (HAS_COMP != 0) begin : g_comp
         assign out_n_o = (gate_i && cen_i) ? (~ref_lvl ^ cpol_i) : cpol_i;
      end else begin : g_nocomp
         assign out_n_o = cen_i & cpol_i;
      end
   endgenerate

   assert_cmp_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_i && en_i && cmp_i == '0) |-> (out_o == pol_i));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
   import pwmt_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int HAS_COMP = 1,
   parameter int NUM_BRK  = 2,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [3:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [3:0]         rd_addr,
   output logic [31:0]        rd_data,
   input  logic [NUM_BRK-1:0] brk_in,
   output logic [NUM_CH-1:0]  pwm_out,
   output logic [NUM_CH-1:0]  pwm_out_n
);
   localparam int CFG_W = CFG_STRIDE * NUM_CH;
   localparam int BRK_W = BRK_STRIDE * NUM_BRK;
   localparam logic [CFG_W-1:0] CFG_MASK = {NUM_CH{(HAS_COMP != 0) ? 4'hF : 4'h3}};
   localparam logic [BRK_W-1:0] BRK_MASK = {NUM_BRK{8'hF3}};

   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("NUM_CH must be 1..4");
      end
      if (NUM_BRK < 1 || NUM_BRK > 2) begin : g_bad_brk
         $error("NUM_BRK must be 1..2");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must be 2..32");
      end
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc
         $error("PSC_W must be 1..32");
      end
   endgenerate

   logic             run_q, pre_q, aoe_q, moe_q;
   logic [PSC_W-1:0] psc_b, psc_a;
   logic [CNT_W-1:0] arr_b, arr_a, arr_eff;
   logic [CNT_W-1:0] cmp_b [NUM_CH];
   logic [CNT_W-1:0] cmp_a [NUM_CH];
   logic [CFG_W-1:0] cfg_q;
   logic [BRK_W-1:0] brk_q;
   logic [CNT_W-1:0] cnt;
   logic             upd;
   logic             wr_ctrl;
   logic             ug;
   logic [NUM_BRK-1:0] trip;
   logic             brk_any;
   logic             gate;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^wr_data;
   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign ug      = wr_ctrl && wr_data[B_UG];
   assign arr_eff = pre_q ? arr_a : arr_b;
   assign brk_any = |trip;
   assign gate    = moe_q && !brk_any;

   pwmt_count #(.PSC_W(PSC_W), .CNT_W(CNT_W)) count_i (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .force_i(ug),
      .psc_i(psc_a), .arr_i(arr_eff), .cnt_o(cnt), .upd_o(upd)
   );

   genvar b;
   generate
      for (b = 0; b < NUM_BRK; b++) begin : g_brk
         pwmt_brk #(.FILT_W(FILT_W)) brk_i (
            .clk(clk), .rst_n(rst_n),
            .en_i(brk_q[BRK_STRIDE*b]),
            .lvl_i(brk_q[BRK_STRIDE*b+1]),
            .filt_i(brk_q[BRK_STRIDE*b+4 +: FILT_W]),
            .raw_i(brk_in[b]),
            .trip_o(trip[b])
         );
      end
   endgenerate

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         pwmt_chan #(.CNT_W(CNT_W), .HAS_COMP(HAS_COMP)) chan_i (
            .clk(clk), .rst_n(rst_n),
            .cnt_i(cnt), .cmp_i(cmp_a[c]),
            .en_i(cfg_q[CFG_STRIDE*c]),
            .pol_i(cfg_q[CFG_STRIDE*c+1]),
            .cen_i(cfg_q[CFG_STRIDE*c+2]),
            .cpol_i(cfg_q[CFG_STRIDE*c+3]),
            .gate_i(gate),
            .out_o(pwm_out[c]),
            .out_n_o(pwm_out_n[c])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pre_q <= 1'b0;
         aoe_q <= 1'b0;
         moe_q <= 1'b0;
         psc_b <= '0;
         psc_a <= '0;
         arr_b <= '0;
         arr_a <= '0;
         cfg_q <= '0;
         brk_q <= '0;
         for (int i = 0; i < NUM_CH; i++) begin
            cmp_b[i] <= '0;
            cmp_a[i] <= '0;
         end
      end else begin
         if (wr_en) begin
            case (wr_addr)
               A_CTRL: begin
                  run_q <= wr_data[B_RUN];
                  pre_q <= wr_data[B_PRE];
                  aoe_q <= wr_data[B_AOE];
               end
               A_PRESC:  psc_b <= wr_data[PSC_W-1:0];
               A_RELOAD: arr_b <= wr_data[CNT_W-1:0];
               A_CHCFG:  cfg_q <= wr_data[CFG_W-1:0] & CFG_MASK;
               A_BRK:    brk_q <= wr_data[BRK_W-1:0] & BRK_MASK;
               default: begin
                  for (int i = 0; i < NUM_CH; i++)
                     if (wr_addr == 4'(A_CMP0 + i)) cmp_b[i] <= wr_data[CNT_W-1:0];
               end
            endcase
         end
         if (upd) begin
            psc_a <= psc_b;
            arr_a <= arr_b;
            for (int i = 0; i < NUM_CH; i++) cmp_a[i] <= cmp_b[i];
         end
         if (brk_any)             moe_q <= 1'b0;
         else if (wr_ctrl)        moe_q <= wr_data[B_MOE];
         else if (upd && aoe_q)   moe_q <= 1'b1;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:   rd_data[4:0] = {1'b0, moe_q, aoe_q, pre_q, run_q};
         A_PRESC:  rd_data[PSC_W-1:0] = psc_b;
         A_RELOAD: rd_data[CNT_W-1:0] = arr_b;
         A_CHCFG:  rd_data[CFG_W-1:0] = cfg_q;
         A_BRK:    rd_data[BRK_W-1:0] = brk_q;
         default: begin
            for (int i = 0; i < NUM_CH; i++)
               if (rd_addr == 4'(A_CMP0 + i)) rd_data[CNT_W-1:0] = cmp_b[i];
         end
      endcase
   end

   assert_brk_drops_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      brk_any |=> !moe_q);

   assert_drive_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(moe_q) |-> ($past(wr_ctrl && wr_data[B_MOE]) || $past(upd && aoe_q)));
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
   localparam int NCH = 3;
   localparam int NBK = 1;
   localparam int CW  = 4;
   localparam int PW  = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [3:0]     wr_addr = '0;
   logic [31:0]    wr_data = '0;
   logic [3:0]     rd_addr = '0;
   logic [31:0]    rd_data;
   logic [NBK-1:0] brk_in = '0;
   logic [NCH-1:0] pwm_out, pwm_out_n;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    chk_on = 1'b0;

   pwm_timer #(.NUM_CH(NCH), .HAS_COMP(1), .NUM_BRK(NBK), .CNT_W(CW), .PSC_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .brk_in(brk_in),
      .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
   );

   // reference state, updated from the requirement text
   logic          m_run, m_pre, m_aoe, m_moe;
   logic [PW-1:0] m_psc_b, m_psc_a, m_pc;
   logic [CW-1:0] m_arr_b, m_arr_a, m_cnt;
   logic [CW-1:0] m_cmp_b [NCH];
   logic [CW-1:0] m_cmp_a [NCH];
   logic [4*NCH-1:0] m_cfg;
   logic [8*NBK-1:0] m_brk;
   logic [3:0]    m_r [NBK];

   function automatic logic m_trip_any();
      logic t = 1'b0;
      for (int b = 0; b < NBK; b++)
         if (m_brk[8*b] && (brk_in[b] == m_brk[8*b+1]) && (m_r[b] >= m_brk[8*b+4 +: 4])) t = 1'b1;
      return t;
   endfunction

   always @(posedge clk) begin : model
      logic ug, tick, wrap, upd, brk, act;
      logic [CW-1:0] ae;
      if (!rst_n) begin
         m_run <= 0; m_pre <= 0; m_aoe <= 0; m_moe <= 0;
         m_psc_b <= '0; m_psc_a <= '0; m_pc <= '0;
         m_arr_b <= '0; m_arr_a <= '0; m_cnt <= '0;
         m_cfg <= '0; m_brk <= '0;
         for (int c = 0; c < NCH; c++) begin m_cmp_b[c] <= '0; m_cmp_a[c] <= '0; end
         for (int b = 0; b < NBK; b++) m_r[b] <= '0;
      end else begin
         brk  = m_trip_any();
         ae   = m_pre ? m_arr_a : m_arr_b;
         ug   = wr_en && wr_addr == 4'd0 && wr_data[4];
         tick = m_run && (m_pc >= m_psc_a);
         wrap = tick && (m_cnt >= ae);
         upd  = ug || wrap;
         if (ug) begin m_pc <= '0; m_cnt <= '0; end
         else if (tick) begin m_pc <= '0; m_cnt <= wrap ? '0 : m_cnt + 1'b1; end
         else if (m_run) m_pc <= m_pc + 1'b1;
         if (upd) begin
            m_psc_a <= m_psc_b; m_arr_a <= m_arr_b;
            for (int c = 0; c < NCH; c++) m_cmp_a[c] <= m_cmp_b[c];
         end
         for (int b = 0; b < NBK; b++) begin
            act = m_brk[8*b] && (brk_in[b] == m_brk[8*b+1]);
            m_r[b] <= !act ? 4'd0 : (m_r[b] == 4'hF ? 4'hF : m_r[b] + 4'd1);
         end
         if (wr_en) begin
            case (wr_addr)
               4'd0: begin m_run <= wr_data[0]; m_pre <= wr_data[1]; m_aoe <= wr_data[2]; end
               4'd1: m_psc_b <= wr_data[PW-1:0];
               4'd2: m_arr_b <= wr_data[CW-1:0];
               4'd3: m_cfg <= wr_data[4*NCH-1:0];
               4'd4: m_brk <= wr_data[8*NBK-1:0] & {NBK{8'hF3}};
               default: for (int c = 0; c < NCH; c++) if (wr_addr == 4'(8 + c)) m_cmp_b[c] <= wr_data[CW-1:0];
            endcase
         end
         if (brk) m_moe <= 0;
         else if (wr_en && wr_addr == 4'd0) m_moe <= wr_data[3];
         else if (upd && m_aoe) m_moe <= 1;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // every cycle: compare both output vectors with the reference
   always @(negedge clk) begin
      if (chk_on) begin
         logic gate, rl;
         logic [NCH-1:0] eo, en_n;
         gate = m_moe && !m_trip_any();
         for (int c = 0; c < NCH; c++) begin
            rl = m_cnt < m_cmp_a[c];
            eo[c]   = (gate && m_cfg[4*c])   ? (rl ^ m_cfg[4*c+1])  : m_cfg[4*c+1];
            en_n[c] = (gate && m_cfg[4*c+2]) ? (!rl ^ m_cfg[4*c+3]) : m_cfg[4*c+3];
         end
         chk("pwm_out", 32'(pwm_out), 32'(eo));
         chk("pwm_out_n", 32'(pwm_out_n), 32'(en_n));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string what);
      @(negedge clk); #1;
      rd_addr = a;
      #1;
      chk(what, rd_data, exp);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired, run did not finish");
      summary();
      $finish;
   end

   initial begin : main
      int arrs [3] = '{1, 6, 15};
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      chk_on = 1'b1;
      // R1: reset values
      tag = "R1";
      chk("R1 out idle", 32'(pwm_out), 32'd0);
      rd_chk(4'd0, 32'd0, "R1 ctrl");
      rd_chk(4'd1, 32'd0, "R1 presc");
      rd_chk(4'd2, 32'd0, "R1 reload");
      rd_chk(4'd3, 32'd0, "R1 chcfg");
      rd_chk(4'd4, 32'd0, "R1 brk");
      rd_chk(4'd8, 32'd0, "R1 cmp0");
      idle(4);

      // R2 R3 R4 R5: sweep prescaler, reload, compares and polarities
      tag = "R2 R3 R4 R5";
      for (int p = 0; p < 4; p++)
         for (int ai = 0; ai < 3; ai++)
            for (int v = 0; v < 2; v++) begin
               int a = arrs[ai];
               logic [31:0] cfg = 0;
               for (int c = 0; c < NCH; c++) begin
                  logic pl = (v ^ c) & 1;
                  cfg[4*c +: 4] = {~pl, 1'b1, pl, 1'b1};
               end
               wr(4'd1, 32'(p));
               wr(4'd2, 32'(a));
               wr(4'd8, 32'd0);
               wr(4'd9, 32'(a / 2 + v));
               wr(4'd10, (a == 15) ? 32'd15 : 32'(a + 1));
               wr(4'd3, cfg);
               wr(4'd0, 32'h19 | (v << 1));
               idle((p + 1) * (a + 1) * 2 + 2);
            end

      // R6: buffered and direct reload
      tag = "R6";
      wr(4'd1, 0); wr(4'd2, 9); wr(4'd8, 4); wr(4'd3, 32'h201);
      wr(4'd0, 32'h1B);
      idle(3);
      wr(4'd2, 3);
      idle(30);
      wr(4'd0, 32'h09);
      wr(4'd2, 12);
      idle(30);
      wr(4'd2, 2);
      idle(20);

      // R7: buffer writes without update change nothing, then update request
      tag = "R7";
      wr(4'd0, 32'h08);
      wr(4'd1, 3); wr(4'd8, 7); wr(4'd9, 2); wr(4'd2, 10);
      idle(10);
      wr(4'd0, 32'h19);
      idle(100);

      // R8: run bit clear freezes the counter
      tag = "R8";
      wr(4'd0, 32'h08);
      idle(20);
      wr(4'd0, 32'h09);
      idle(20);

      // R9: drive flag clear
      tag = "R9";
      wr(4'd3, 32'hAEB);
      wr(4'd0, 32'h01);
      idle(20);
      wr(4'd0, 32'h09);
      idle(10);

      // R10: break filter, levels, disable
      tag = "R10";
      wr(4'd1, 0); wr(4'd2, 7); wr(4'd0, 32'h19);
      wr(4'd4, 32'h33);
      @(negedge clk); #1 brk_in = 1'b1;
      idle(3);
      #1 brk_in = 1'b0;
      idle(5);
      rd_chk(4'd0, 32'h09, "R10 short pulse keeps drive");
      #1 brk_in = 1'b1;
      idle(6);
      #1 brk_in = 1'b0;
      idle(10);
      rd_chk(4'd0, 32'h01, "R10 trip clears drive");
      wr(4'd0, 32'h09);
      idle(5);
      wr(4'd4, 32'h01);
      idle(5);
      rd_chk(4'd0, 32'h01, "R10 active-low trip");
      #1 brk_in = 1'b1;
      wr(4'd4, 32'h00);
      wr(4'd0, 32'h09);
      #1 brk_in = 1'b0;
      idle(5);
      #1 brk_in = 1'b1;
      idle(5);
      rd_chk(4'd0, 32'h09, "R10 disabled input ignored");

      // R11: automatic drive restore
      tag = "R11";
      #1 brk_in = 1'b0;
      wr(4'd0, 32'h0D);
      wr(4'd4, 32'h03);
      #1 brk_in = 1'b1;
      idle(5);
      #1 brk_in = 1'b0;
      idle(30);
      rd_chk(4'd0, 32'h0D, "R11 restored at update");
      wr(4'd0, 32'h09);
      #1 brk_in = 1'b1;
      idle(3);
      #1 brk_in = 1'b0;
      idle(30);
      rd_chk(4'd0, 32'h01, "R11 stays clear without restore");

      // R12: readback of absent resources
      tag = "R12";
      wr(4'd4, 32'h0);
      wr(4'd3, 32'hFFFF_FFFF);
      rd_chk(4'd3, 32'h0000_0FFF, "R12 chcfg mask");
      wr(4'd4, 32'hFFFF_FFFF);
      rd_chk(4'd4, 32'h0000_00F3, "R12 brk mask");
      wr(4'd4, 32'h0);
      wr(4'd11, 32'h5);
      rd_chk(4'd11, 32'h0, "R12 missing compare");
      wr(4'd1, 32'hFF);
      rd_chk(4'd1, 32'h3, "R12 presc width");
      wr(4'd2, 32'hFFFF);
      rd_chk(4'd2, 32'hF, "R12 reload width");
      wr(4'd0, 32'h1F);
      rd_chk(4'd0, 32'h0F, "R12 update bit reads zero");
      idle(20);

      chk_on = 1'b0;
      summary();
      $finish;
   end
endmodule